// File: doc/BRIEF.md
# Memory Device Test Access Port

This block is the boundary-scan test port of a synchronous memory device. A serial test controller drives a test clock, a mode-select line and a serial data input. It walks a sixteen-state controller through capture, shift and update phases. The selected register comes back on a serial output that changes on the falling edge of the test clock.

Three instructions do work. The first identifies the part through a fixed 32-bit word. The second drives the pads from a boundary register. The third samples every pin while it forces the memory's data outputs to high impedance, and the block exports that request to the functional data path. Every other opcode connects the one-bit bypass stage.

There is no dedicated test reset pin. A power-on reset, or five test clocks with mode-select high, returns the port to its reset state. Undriven mode-select and data pins are pulled to logic 1 outside this block, so an idle port stays in its reset state.

Top module: `sram_tap`

## Requirements
- R1: After power-on reset the controller sits in Test-Logic-Reset. The ID instruction is active, `tdo_oe`, `outs_hiz` and `extest_on` are 0 and `bnd_drv` is all zero. A data scan taken without first loading an instruction returns the ID word.
- R2: The controller follows the standard sixteen-state transitions on TMS at the rising TCK edge. Five consecutive edges with TMS at 1 reach Test-Logic-Reset from any state.
- R3: The instruction register is 3 bits and shifts least significant bit first. Capture-IR loads 3'b001, so the bits 1, 0, 0 appear first on TDO. A shifted opcode becomes active at the rising edge that leaves Update-IR.
- R4: TDO changes only on the falling edge of TCK. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R5: Opcode 3'b001 selects the 32-bit ID register, which captures {revision[31:29]=0, device[28:12]=17'h00294, vendor[11:1]=11'h0B3, bit0=1} and shifts out LSB first.
- R6: Opcode 3'b111 and the unused opcodes 3'b011, 3'b100, 3'b101 and 3'b110 select the 1-bit bypass stage. It captures 0, so a scan returns 0 followed by the TDI bits delayed by one.
- R7: Opcode 3'b010 drives `outs_hiz` to 1 and `extest_on` to 0. The boundary register captures `bnd_pins`, and Update-DR leaves `bnd_drv` unchanged.
- R8: Opcode 3'b000 drives `extest_on` to 1 and `outs_hiz` to 0. The boundary register captures `bnd_pins`, and at the edge leaving Update-DR `bnd_drv` takes the shifted contents.
- R9: With the default exit order (CELL0_FIRST=1), boundary cell 0 is the cell nearest TDO. It is the first bit shifted out and receives the first bit shifted in.
- R10: Entering Test-Logic-Reset restores the ID instruction and clears `outs_hiz` and `extest_on` one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in, sampled on rising TCK |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO driver enable |
| bnd_pins | input | BSR_LEN | Pin values captured by the boundary register |
| bnd_drv | output | BSR_LEN | Boundary update values driven to the pads under EXTEST |
| extest_on | output | 1 | Pads driven from `bnd_drv` |
| outs_hiz | output | 1 | Request to place the memory data outputs in high impedance |

## Verification
A wrong controller state shows up within a scan or two. The captured instruction pattern or the ID bits arrive misplaced, or `tdo_oe` rises outside a shift phase. An instruction register that decodes wrongly shows at once on `outs_hiz` and `extest_on` after Update-IR, and on the next data scan it returns the wrong register's capture value. A boundary mapping or update fault shows on `bnd_drv` one edge after Update-DR, and in the order in which pin values leave TDO.

// File: rtl/memtap_pkg.sv
package memtap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR,
    ST_EX2_DR, ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR,
    ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  localparam int unsigned IR_W = 3;
  localparam int unsigned ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] { SEL_BND, SEL_ID, SEL_BYP } dr_sel_t;

  function automatic dr_sel_t decode_dr(logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPZ: return SEL_BND;
      OP_IDCODE:           return SEL_ID;
      default:             return SEL_BYP;
    endcase
  endfunction
endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
  import memtap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_TLR:    state_nx = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_nx = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_nx = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_nx = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_nx = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_nx = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_nx = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_nx = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_nx = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_nx = tms ? ST_SEL_DR : ST_RTI;
      default:   state_nx = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_nx;
  end
endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
  import memtap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_q,
  output dr_sel_t         dr_sel,
  output logic            outs_hiz,
  output logic            extest_on
);
  logic sh_cap, sh_en, ir_load, ir_rst;

  assign sh_cap  = (state == ST_CAP_IR);
  assign sh_en   = (state == ST_SH_IR);
  assign ir_load = (state == ST_UPD_IR);
  assign ir_rst  = (state == ST_TLR);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      ir_sh <= '0;
    else if (sh_cap) ir_sh <= IR_CAPTURE;
    else if (sh_en)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       ir_q <= OP_IDCODE;
    else if (ir_rst)  ir_q <= OP_IDCODE;
    else if (ir_load) ir_q <= ir_sh;
  end

  assign dr_sel    = decode_dr(ir_q);
  assign outs_hiz  = (ir_q == OP_SAMPZ);
  assign extest_on = (ir_q == OP_EXTEST);
endmodule

// File: rtl/memtap_dr.sv
module memtap_dr
  import memtap_pkg::*;
#(
  parameter int unsigned     BSR_LEN     = 107,
  parameter bit              CELL0_FIRST = 1'b1,
  parameter logic [ID_W-1:0] ID_WORD     = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tdi,
  input  tap_state_t         state,
  input  dr_sel_t            dr_sel,
  input  logic               extest_on,
  input  logic [BSR_LEN-1:0] bnd_pins,
  output logic [BSR_LEN-1:0] bnd_drv,
  output logic               byp_q,
  output logic               dr_lsb
);
  logic [ID_W-1:0]    id_sh;
  logic [BSR_LEN-1:0] bsr_sh, cap_vec, drv_map;
  logic cap_en, sh_en, upd_en;

  assign cap_en = (state == ST_CAP_DR);
  assign sh_en  = (state == ST_SH_DR);
  assign upd_en = (state == ST_UPD_DR);

  // Exit order: which pin each shift stage maps to.
  for (genvar g = 0; g < BSR_LEN; g++) begin : g_map
    if (CELL0_FIRST) begin : g_fwd
      assign cap_vec[g] = bnd_pins[g];
      assign drv_map[g] = bsr_sh[g];
    end else begin : g_rev
      assign cap_vec[g] = bnd_pins[BSR_LEN-1-g];
      assign drv_map[g] = bsr_sh[BSR_LEN-1-g];
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                byp_q <= 1'b0;
    else if (dr_sel == SEL_BYP && cap_en)      byp_q <= 1'b0;
    else if (dr_sel == SEL_BYP && sh_en)       byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                id_sh <= '0;
    else if (dr_sel == SEL_ID && cap_en)       id_sh <= ID_WORD;
    else if (dr_sel == SEL_ID && sh_en)        id_sh <= {tdi, id_sh[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                bsr_sh <= '0;
    else if (dr_sel == SEL_BND && cap_en)      bsr_sh <= cap_vec;
    else if (dr_sel == SEL_BND && sh_en)       bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                bnd_drv <= '0;
    else if (extest_on && upd_en)              bnd_drv <= drv_map;
  end

  always_comb begin
    case (dr_sel)
      SEL_ID:  dr_lsb = id_sh[0];
      SEL_BND: dr_lsb = bsr_sh[0];
      default: dr_lsb = byp_q;
    endcase
  end
endmodule

// File: rtl/sram_tap.sv
module sram_tap
  import memtap_pkg::*;
#(
  parameter int unsigned BSR_LEN     = 107,
  parameter bit          CELL0_FIRST = 1'b1,
  parameter logic [2:0]  ID_REV      = 3'd0,
  parameter logic [16:0] ID_DEV      = 17'h00294,
  parameter logic [10:0] ID_VEN      = 11'h0B3
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] bnd_pins,
  output logic [BSR_LEN-1:0] bnd_drv,
  output logic               extest_on,
  output logic               outs_hiz
);
  localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_DEV, ID_VEN, 1'b1};

  logic [1:0]      rst_sync;
  logic            rst_n;
  tap_state_t      state;
  logic [IR_W-1:0] ir_sh, ir_q;
  dr_sel_t         dr_sel;
  logic            byp_q, dr_lsb;
  logic            in_sh_ir, in_sh_dr;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  memtap_fsm u_fsm (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(state)
  );

  memtap_ir u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
    .ir_sh(ir_sh), .ir_q(ir_q), .dr_sel(dr_sel),
    .outs_hiz(outs_hiz), .extest_on(extest_on)
  );

  memtap_dr #(.BSR_LEN(BSR_LEN), .CELL0_FIRST(CELL0_FIRST), .ID_WORD(ID_WORD)) u_dr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state), .dr_sel(dr_sel),
    .extest_on(extest_on), .bnd_pins(bnd_pins), .bnd_drv(bnd_drv),
    .byp_q(byp_q), .dr_lsb(dr_lsb)
  );

  assign in_sh_ir = (state == ST_SH_IR);
  assign in_sh_dr = (state == ST_SH_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_sh_ir | in_sh_dr;
      if (in_sh_ir)      tdo <= ir_sh[0];
      else if (in_sh_dr) tdo <= dr_lsb;
    end
  end
endmodule

// File: rtl/memtap_chk.sv
module memtap_chk
  import memtap_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input tap_state_t      state,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sh,
  input logic            byp_q,
  input dr_sel_t         dr_sel,
  input logic            tdo_oe,
  input logic            outs_hiz,
  input logic            extest_on
);
  // R10
  tlr_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (ir_q == OP_IDCODE));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE));

  // R6
  bypass_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && dr_sel == SEL_BYP) |=> !byp_q);

  // R2
  tms_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> (state == ST_TLR));

  // R7
  mode_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({outs_hiz, extest_on}));

  // R4
  tdo_oe_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
endmodule

bind sram_tap memtap_chk u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .state(state), .ir_q(ir_q),
  .ir_sh(ir_sh), .byp_q(byp_q), .dr_sel(dr_sel), .tdo_oe(tdo_oe),
  .outs_hiz(outs_hiz), .extest_on(extest_on)
);

// File: tb/sram_tap_test.sv
module sram_tap_test;
  localparam int N = 107;
  localparam logic [31:0] ID_EXP = {3'd0, 17'h00294, 11'h0B3, 1'b1};

  // {opcode[6:4], kind[3:2] (0 boundary,1 id,2 bypass), hiz[1], ext[0]}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 2'd0, 1'b0, 1'b1},
    {3'b001, 2'd1, 1'b0, 1'b0},
    {3'b010, 2'd0, 1'b1, 1'b0},
    {3'b011, 2'd2, 1'b0, 1'b0},
    {3'b100, 2'd2, 1'b0, 1'b0},
    {3'b101, 2'd2, 1'b0, 1'b0},
    {3'b110, 2'd2, 1'b0, 1'b0},
    {3'b111, 2'd2, 1'b0, 1'b0}
  };

  logic tck = 1'b0;
  logic por_n, tms, tdi;
  logic tdo, tdo_oe, extest_on, outs_hiz;
  logic [N-1:0] bnd_pins, bnd_drv;

  int total = 0;
  int bad = 0;
  logic last_tdo, last_oe, edge_bad;

  always #4 tck = ~tck;

  sram_tap uut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bnd_pins(bnd_pins), .bnd_drv(bnd_drv), .extest_on(extest_on), .outs_hiz(outs_hiz)
  );

  task automatic check(input logic ok, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    @(negedge tck);
    #1;
    last_tdo = tdo;
    last_oe  = tdo_oe;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
    if (tdo !== last_tdo) edge_bad = 1'b1;
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap, output logic oe_all);
    oe_all = 1'b1;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, op[i]);
      cap[i] = last_tdo;
      oe_all &= last_oe;
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout,
                         output logic oe_all);
    dout = '0;
    oe_all = 1'b1;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      dout[i] = last_tdo;
      oe_all &= last_oe;
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0]   cap;
    logic [127:0] dout, din, exp;
    logic         oe;
    logic [N-1:0] drv_keep;
    logic [2:0]   op;
    logic [1:0]   kind;

    edge_bad = 1'b0;
    for (int i = 0; i < N; i++) bnd_pins[i] = ((i % 3) == 1) ^ ((i % 5) == 0);
    por_n = 1'b0; tms = 1'b1; tdi = 1'b1;
    repeat (3) @(posedge tck);
    #1;
    // R1: reset state at the ports
    check(tdo_oe == 0 && outs_hiz == 0 && extest_on == 0, "R1 reset outputs",
          {tdo_oe, outs_hiz, extest_on}, 0);
    check(bnd_drv == '0, "R1 reset bnd_drv", bnd_drv, 0);
    por_n = 1'b1;
    repeat (4) tick(1, 1);
    tick(0, 0);
    check(tdo_oe == 0, "R4 tdo_oe idle", tdo_oe, 0);

    // R1 R5: ID word without instruction load
    scan_dr(32, '0, dout, oe);
    check(dout[31:0] == ID_EXP, "R1 R5 default ID scan", dout[31:0], ID_EXP);
    check(oe, "R4 tdo_oe during shift", oe, 1);

    // Table walk over all opcodes
    din = 128'hA5;
    for (int v = 0; v < 8; v++) begin
      op   = VEC[v][6:4];
      kind = VEC[v][3:2];
      scan_ir(op, cap, oe);
      check(cap == 3'b001, $sformatf("R3 IR capture op=%0d", op), cap, 3'b001);
      check(oe, "R4 tdo_oe in Shift-IR", oe, 1);
      #1;
      check(outs_hiz == VEC[v][1], $sformatf("R7 outs_hiz op=%0d", op), outs_hiz, VEC[v][1]);
      check(extest_on == VEC[v][0], $sformatf("R8 extest_on op=%0d", op), extest_on, VEC[v][0]);
      scan_dr(8, din, dout, oe);
      exp = '0;
      for (int i = 0; i < 8; i++) begin
        if (kind == 2'd0)      exp[i] = bnd_pins[i];
        else if (kind == 2'd1) exp[i] = ID_EXP[i];
        else                   exp[i] = (i == 0) ? 1'b0 : din[i-1];
      end
      check(dout[7:0] == exp[7:0], $sformatf("R5 R6 R7 DR scan op=%0d", op), dout[7:0], exp[7:0]);
    end

    // R8 R9: full EXTEST scan and update
    scan_ir(3'b000, cap, oe);
    din = '0;
    for (int i = 0; i < N; i++) din[i] = ((i % 4) == 2) || ((i % 7) == 0);
    scan_dr(N, din, dout, oe);
    check(dout[N-1:0] == bnd_pins, "R9 pin capture order", dout[N-1:0], bnd_pins);
    check(bnd_drv == din[N-1:0], "R8 R9 EXTEST update", bnd_drv, din[N-1:0]);
    drv_keep = bnd_drv;

    // R7: SAMPLE-Z update must not alter bnd_drv
    scan_ir(3'b010, cap, oe);
    scan_dr(N, ~din, dout, oe);
    check(dout[N-1:0] == bnd_pins, "R7 sample capture", dout[N-1:0], bnd_pins);
    check(bnd_drv == drv_keep, "R7 bnd_drv held", bnd_drv, drv_keep);
    check(outs_hiz == 1, "R7 outs_hiz held", outs_hiz, 1);

    // R2 R10: TMS high from Pause-DR returns to reset
    tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    repeat (6) tick(1, 0);
    check(outs_hiz == 0 && extest_on == 0, "R10 modes cleared",
          {outs_hiz, extest_on}, 0);
    tick(0, 0);
    scan_dr(32, '0, dout, oe);
    check(dout[31:0] == ID_EXP, "R2 R10 ID after TMS reset", dout[31:0], ID_EXP);

    check(!edge_bad, "R4 TDO stable at rising edge", edge_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule